// File: doc/BRIEF.md
# Data Acquisition Card Register Interface

This block sits on a byte-wide host bus and turns accesses at offsets 0 to 19 above a card's base address into the controls of a multi-function data acquisition card. The host starts an analog-to-digital conversion by writing any value to offset 0. When the converter signals completion, the block stores the 12-bit result and the number of the channel it came from. The host then reads the result back as two bytes. The result is offset binary: code 0 means minus full scale and code 4095 means plus full scale.

The block also holds several registers:
- a channel multiplexer setting;
- a 4-bit digital output latch, next to a 4-bit digital input;
- two 12-bit analog output codes, each loaded in two byte writes and updated all at once;
- a control register whose bit 0 enables the completion interrupt;
- a status byte, with an interrupt reset written at the same offset.

The counter/timer and parallel-port chips on the card are outside this block. Their offsets only produce chip selects. The converter is reached through a start pulse and a done/result handshake.

Top module: `daq_regif`

## Requirements
- R1: A write of any data to offset 0 makes `conv_start` high for exactly the one cycle after the write cycle, and the written data has no other effect.
- R2: On a cycle with `conv_done` high, the block stores `conv_result` and the low four bits of the multiplexer register. A read of offset 0 then returns result bits 3:0 in bits 7:4 and the channel in bits 3:0. A read of offset 1 returns result bits 11:4.
- R3: A write to offset 1 changes nothing: the offset 1 and offset 0 reads are unchanged afterwards.
- R4: Offset 2 is an 8-bit multiplexer register that reads back what was written. Its low four bits drive `chan_sel`.
- R5: A write to offset 3 loads bits 3:0 of the data into `dio_out`. A read of offset 3 returns `dio_in` in bits 3:0, with zeros above.
- R6: A write to offset 4 (code 0) or 6 (code 1) stages data bits 7:4 as the four low code bits. A later write to offset 5 or 7 loads the code as {data, staged nibble} in one step. The output code does not change on the staging write.
- R7: The status byte at offset 8 has end-of-conversion in bit 7, `bipolar_mode` in bit 6, interrupt pending in bit 5 and `chan_sel` in bits 3:0. End-of-conversion is cleared by a start write and set by `conv_done`. When both happen in the same cycle, the start wins.
- R8: Offset 9 is a read/write control byte; bit 0 enables interrupts. `conv_done` with bit 0 set raises `irq`. A write to offset 8 clears it; a set in the same cycle wins over the clear.
- R9: While `bus_rd` or `bus_wr` is high, offsets 12 to 15 assert `tmr_cs` and offsets 16 to 19 assert `pio_cs`. Reads of offsets 4 to 7 and 10 to 19 return zero.
- R10: After reset, all registers, outputs and readable bytes are zero, except the status bit that mirrors `bipolar_mode`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 5 | Offset from the base address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from the offset |
| conv_start | output | 1 | One-cycle conversion start |
| conv_done | input | 1 | Converter completion, one cycle |
| conv_result | input | 12 | Converter result, valid with conv_done |
| chan_sel | output | 4 | Multiplexer channel |
| dio_out | output | 4 | Digital output latch |
| dio_in | input | 4 | Digital input port |
| dac0_code | output | 12 | Analog output code 0 |
| dac1_code | output | 12 | Analog output code 1 |
| bipolar_mode | input | 1 | Input range jumper, 1 for bipolar |
| irq | output | 1 | Interrupt request |
| tmr_cs | output | 1 | Counter/timer chip select |
| pio_cs | output | 1 | Parallel-port chip select |

## Verification
Conversions are run with mid-scale, all-zero and all-ones results on different channels. A nibble or byte swap in the result packing shows up in the mid-scale case, and stuck bits show up at the two extremes. The multiplexer is changed between conversions to show that the stored channel is the one in force when the result arrived. Analog output codes are loaded with the staging write alone and then with the full pair, on both codes, which exposes early updates and crossed offsets. Interrupts are tried with the enable bit set and cleared, and with a clear that coincides with a completion.

// File: rtl/daq_pkg.sv
// Shared constants for the data acquisition register interface.
// Assumes a 5-bit offset bus and byte-wide data.
package daq_pkg;
    localparam int ADDR_W   = 5;
    localparam int DATA_W   = 8;
    localparam int RES_W    = 12;
    localparam int CH_W     = 4;
    localparam int NUM_OFF  = 20;
    localparam int NUM_DAC  = 2;

    localparam int OFF_ADC_LO  = 0;
    localparam int OFF_ADC_HI  = 1;
    localparam int OFF_MUX     = 2;
    localparam int OFF_DIO     = 3;
    localparam int OFF_DAC_LO  = 4;   // code n low at 4+2n, high at 5+2n
    localparam int OFF_STAT    = 8;
    localparam int OFF_CTRL    = 9;
    localparam int OFF_TMR_LO  = 12;
    localparam int OFF_TMR_HI  = 15;
    localparam int OFF_PIO_LO  = 16;
    localparam int OFF_PIO_HI  = 19;

    localparam int STAT_EOC    = 7;
    localparam int STAT_BIP    = 6;
    localparam int STAT_IRQ    = 5;
    localparam int CTRL_IEN    = 0;
endpackage

// File: rtl/daq_addr_dec.sv
// Offset decoder: one write strobe per local offset, plus chip selects
// for the two external chip windows. Assumes one offset per access.
module daq_addr_dec
    import daq_pkg::*;
#(
    parameter int AW   = ADDR_W,
    parameter int NOFF = NUM_OFF
) (
    input  logic [AW-1:0]   addr,
    input  logic            wr,
    input  logic            rd,
    output logic [NOFF-1:0] wr_hit,
    output logic            tmr_cs,
    output logic            pio_cs
);
    localparam int OW = $clog2(NOFF + 1);

    genvar g;
    generate
        for (g = 0; g < NOFF; g++) begin : g_hit
            // per-offset write strobe
            assign wr_hit[g] = wr && (addr == AW'(g));
        end
    endgenerate

    // external chip windows, active during either strobe
    always_comb begin
        tmr_cs = (rd || wr) && (int'(addr) >= OFF_TMR_LO) && (int'(addr) <= OFF_TMR_HI);
        pio_cs = (rd || wr) && (int'(addr) >= OFF_PIO_LO) && (int'(addr) <= OFF_PIO_HI);
    end
endmodule

// File: rtl/daq_adc_capture.sv
// Conversion control: issues the start pulse, latches result and channel
// on done, keeps end-of-conversion and the interrupt pending flag.
// Assumes done is a single-cycle pulse with result valid alongside.
module daq_adc_capture
    import daq_pkg::*;
#(
    parameter int RW = RES_W,
    parameter int CW = CH_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_wr,
    input  logic          done,
    input  logic [RW-1:0] result,
    input  logic [CW-1:0] chan,
    input  logic          irq_en,
    input  logic          irq_clr,
    output logic          start_pulse,
    output logic [RW-1:0] res_q,
    output logic [CW-1:0] ch_q,
    output logic          eoc,
    output logic          irq_pend
);
    // start pulse follows the write by one cycle
    always_ff @(posedge clk) begin
        if (!rst_n) start_pulse <= 1'b0;
        else        start_pulse <= start_wr;
    end

    // capture result and channel on completion
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q <= '0;
            ch_q  <= '0;
        end else if (done) begin
            res_q <= result;
            ch_q  <= chan;
        end
    end

    // end-of-conversion flag, start has priority
    always_ff @(posedge clk) begin
        if (!rst_n)        eoc <= 1'b0;
        else if (start_wr) eoc <= 1'b0;
        else if (done)     eoc <= 1'b1;
    end

    // interrupt pending, a new event wins over a clear
    always_ff @(posedge clk) begin
        if (!rst_n)                irq_pend <= 1'b0;
        else if (done && irq_en)   irq_pend <= 1'b1;
        else if (irq_clr)          irq_pend <= 1'b0;
    end
endmodule

// File: rtl/daq_dac_stage.sv
// One analog output code: the low nibble is staged, and the full code
// updates in one step when the high byte is written.
module daq_dac_stage
    import daq_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int RW = RES_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          lo_wr,
    input  logic          hi_wr,
    input  logic [DW-1:0] wdata,
    output logic [RW-1:0] code
);
    localparam int LW = RW - DW;

    logic [LW-1:0] stage_q;

    // hold the low bits from the top of the data byte
    always_ff @(posedge clk) begin
        if (!rst_n)     stage_q <= '0;
        else if (lo_wr) stage_q <= wdata[DW-1 -: LW];
    end

    // load the whole code on the high byte write
    always_ff @(posedge clk) begin
        if (!rst_n)     code <= '0;
        else if (hi_wr) code <= {wdata, stage_q};
    end
endmodule

// File: rtl/daq_regif.sv
// Top of the acquisition card register interface. Decodes the offset,
// holds the local registers and returns read data combinationally.
// Assumes write strobes last one cycle per access.
module daq_regif
    import daq_pkg::*;
#(
    parameter int AW   = ADDR_W,
    parameter int DW   = DATA_W,
    parameter int RW   = RES_W,
    parameter int CW   = CH_W,
    parameter int NOFF = NUM_OFF
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] bus_addr,
    input  logic          bus_wr,
    input  logic          bus_rd,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    output logic          conv_start,
    input  logic          conv_done,
    input  logic [RW-1:0] conv_result,
    output logic [CW-1:0] chan_sel,
    output logic [CW-1:0] dio_out,
    input  logic [CW-1:0] dio_in,
    output logic [RW-1:0] dac0_code,
    output logic [RW-1:0] dac1_code,
    input  logic          bipolar_mode,
    output logic          irq,
    output logic          tmr_cs,
    output logic          pio_cs
);
    localparam int LOW_W = RW - DW;

    logic [NOFF-1:0] wr_hit;
    logic [DW-1:0]   mux_q;
    logic [DW-1:0]   ctrl_q;
    logic [RW-1:0]   res_q;
    logic [CW-1:0]   ch_q;
    logic            eoc_q;
    logic            irq_q;
    logic [RW-1:0]   dac_code [NUM_DAC];

    daq_addr_dec #(.AW(AW), .NOFF(NOFF)) u_dec (
        .addr   (bus_addr),
        .wr     (bus_wr),
        .rd     (bus_rd),
        .wr_hit (wr_hit),
        .tmr_cs (tmr_cs),
        .pio_cs (pio_cs)
    );

    // multiplexer, digital output and control registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mux_q   <= '0;
            ctrl_q  <= '0;
            dio_out <= '0;
        end else begin
            if (wr_hit[OFF_MUX])  mux_q   <= bus_wdata;
            if (wr_hit[OFF_CTRL]) ctrl_q  <= bus_wdata;
            if (wr_hit[OFF_DIO])  dio_out <= bus_wdata[CW-1:0];
        end
    end

    assign chan_sel = mux_q[CW-1:0];
    assign irq      = irq_q;

    daq_adc_capture #(.RW(RW), .CW(CW)) u_adc (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_wr    (wr_hit[OFF_ADC_LO]),
        .done        (conv_done),
        .result      (conv_result),
        .chan        (mux_q[CW-1:0]),
        .irq_en      (ctrl_q[CTRL_IEN]),
        .irq_clr     (wr_hit[OFF_STAT]),
        .start_pulse (conv_start),
        .res_q       (res_q),
        .ch_q        (ch_q),
        .eoc         (eoc_q),
        .irq_pend    (irq_q)
    );

    genvar g;
    generate
        for (g = 0; g < NUM_DAC; g++) begin : g_dac
            daq_dac_stage #(.DW(DW), .RW(RW)) u_dac (
                .clk   (clk),
                .rst_n (rst_n),
                .lo_wr (wr_hit[OFF_DAC_LO + 2*g]),
                .hi_wr (wr_hit[OFF_DAC_LO + 2*g + 1]),
                .wdata (bus_wdata),
                .code  (dac_code[g])
            );
        end
    endgenerate

    assign dac0_code = dac_code[0];
    assign dac1_code = dac_code[1];

    // read data selection by offset
    always_comb begin
        bus_rdata = '0;
        case (int'(bus_addr))
            OFF_ADC_LO: bus_rdata = {res_q[LOW_W-1:0], ch_q};
            OFF_ADC_HI: bus_rdata = res_q[RW-1:LOW_W];
            OFF_MUX:    bus_rdata = mux_q;
            OFF_DIO:    bus_rdata = {{(DW-CW){1'b0}}, dio_in};
            OFF_STAT: begin
                bus_rdata[STAT_EOC] = eoc_q;
                bus_rdata[STAT_BIP] = bipolar_mode;
                bus_rdata[STAT_IRQ] = irq_q;
                bus_rdata[CW-1:0]   = mux_q[CW-1:0];
            end
            OFF_CTRL:   bus_rdata = ctrl_q;
            default:    bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/daq_regif_chk.sv
// Property checker for the register interface, attached by bind.
module daq_regif_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [4:0]  bus_addr,
    input logic        bus_wr,
    input logic        conv_done,
    input logic        conv_start,
    input logic        eoc,
    input logic        irq,
    input logic [3:0]  chan_sel,
    input logic [11:0] dac0_code,
    input logic        tmr_cs,
    input logic        pio_cs
);
    AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 5'd0) |=> conv_start);                        // R1
    AST_START_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_addr == 5'd0) |=> !conv_start);                      // R1
    AST_EOC_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_done && !(bus_wr && bus_addr == 5'd0)) |=> eoc);               // R7
    AST_EOC_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> !eoc);                                                 // R7
    AST_DAC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_addr == 5'd5) |=> $stable(dac0_code));               // R6
    AST_MUX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_addr == 5'd2) |=> $stable(chan_sel));                // R4
    AST_IRQ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 5'd8 && !conv_done) |=> !irq);                // R8
    AST_CS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({tmr_cs, pio_cs}));                                          // R9
endmodule

bind daq_regif daq_regif_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_addr   (bus_addr),
    .bus_wr     (bus_wr),
    .conv_done  (conv_done),
    .conv_start (conv_start),
    .eoc        (eoc_q),
    .irq        (irq),
    .chan_sel   (chan_sel),
    .dac0_code  (dac0_code),
    .tmr_cs     (tmr_cs),
    .pio_cs     (pio_cs)
);

// File: tb/tb_daq_regif.sv
// Bench for the register interface: behavioural reference model compared
// every clock, plus directed reads of each offset.
module tb_daq_regif;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        conv_start, conv_done = 1'b0;
    logic [11:0] conv_result = '0;
    logic [3:0]  chan_sel, dio_out, dio_in = '0;
    logic [11:0] dac0_code, dac1_code;
    logic        bipolar_mode = 1'b0;
    logic        irq, tmr_cs, pio_cs;

    int errors = 0, checks = 0;
    bit done_flag = 0;

    always #10 clk = ~clk;   // 50 MHz

    daq_regif dut (.*);

    // reference model state
    int m_mux, m_ctrl, m_dout, m_res, m_ch, m_eoc, m_irq, m_start;
    int m_stage[2], m_dac[2];

    // model update on each rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_mux = 0; m_ctrl = 0; m_dout = 0; m_res = 0; m_ch = 0;
            m_eoc = 0; m_irq = 0; m_start = 0;
            m_stage = '{0, 0}; m_dac = '{0, 0};
        end else begin
            int a; a = bus_addr;
            if (conv_done) begin m_res = conv_result; m_ch = m_mux % 16; m_eoc = 1; end
            m_start = (bus_wr && a == 0);
            if (m_start) m_eoc = 0;
            if (bus_wr && a == 8) m_irq = 0;
            if (conv_done && (m_ctrl % 2 == 1)) m_irq = 1;
            if (bus_wr) begin
                if (a == 2) m_mux = bus_wdata;
                if (a == 3) m_dout = bus_wdata % 16;
                if (a == 9) m_ctrl = bus_wdata;
                if (a == 4 || a == 6) m_stage[(a-4)/2] = bus_wdata / 16;
                if (a == 5 || a == 7) m_dac[(a-5)/2] = bus_wdata * 16 + m_stage[(a-5)/2];
            end
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // per-clock comparison, away from the edge
    always @(posedge clk) begin
        #2;
        if (rst_n) begin
            chk("R1", "conv_start", conv_start, m_start);
            chk("R4", "chan_sel", chan_sel, m_mux % 16);
            chk("R5", "dio_out", dio_out, m_dout);
            chk("R6", "dac0_code", dac0_code, m_dac[0]);
            chk("R6", "dac1_code", dac1_code, m_dac[1]);
            chk("R8", "irq", irq, m_irq);
        end
    end

    task automatic wr(input int a, input int d);
        @(negedge clk); bus_addr = 5'(a); bus_wdata = 8'(d); bus_wr = 1'b1;
        @(negedge clk); bus_wr = 1'b0;
    endtask

    task automatic rd(input int a, input int exp, input string req);
        @(negedge clk); bus_addr = 5'(a); bus_rd = 1'b1;
        #1 chk(req, $sformatf("read offset %0d", a), bus_rdata, exp);
        @(negedge clk); bus_rd = 1'b0;
    endtask

    task automatic done_pulse(input int r);
        @(negedge clk); conv_done = 1'b1; conv_result = 12'(r);
        @(negedge clk); conv_done = 1'b0;
    endtask

    function automatic int stat(input int eoc, input int bip, input int irqv, input int ch);
        return eoc*128 + bip*64 + irqv*32 + ch;
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R10 reset state
        rd(0, 0, "R10"); rd(1, 0, "R10"); rd(8, 0, "R10"); rd(9, 0, "R10");
        chk("R10", "dac0 after reset", dac0_code, 0);
        chk("R10", "irq after reset", irq, 0);

        // R4 multiplexer readback
        wr(2, 8'h35); rd(2, 8'h35, "R4");

        // R1 start write, R7 eoc clear
        wr(0, 8'hA5);
        rd(8, stat(0, 0, 0, 5), "R7");
        // R2 mid-scale result on channel 5
        done_pulse(12'hABC);
        rd(0, 8'hC5, "R2"); rd(1, 8'hAB, "R2");
        rd(8, stat(1, 0, 0, 5), "R7");
        // R3 write to offset 1 has no effect
        wr(1, 8'h55); rd(1, 8'hAB, "R3"); rd(0, 8'hC5, "R3");

        // R2 extremes and channel taken at completion time
        wr(2, 8'h0F); wr(0, 0); done_pulse(12'h000);
        wr(2, 8'h03);
        rd(0, 8'h0F, "R2"); rd(1, 8'h00, "R2");
        wr(0, 0); done_pulse(12'hFFF);
        rd(0, 8'hF3, "R2"); rd(1, 8'hFF, "R2");

        // R7 start and done together: start wins
        @(negedge clk); bus_addr = 5'd0; bus_wr = 1'b1; conv_done = 1'b1; conv_result = 12'h5A6;
        @(negedge clk); bus_wr = 1'b0; conv_done = 1'b0;
        rd(8, stat(0, 0, 0, 3), "R7");
        rd(0, 8'h63, "R2");

        // R8 interrupt enable, clear, set-wins
        wr(9, 8'h01); rd(9, 8'h01, "R8");
        done_pulse(12'h100);
        chk("R8", "irq raised", irq, 1);
        wr(8, 0);
        chk("R8", "irq cleared", irq, 0);
        @(negedge clk); bus_addr = 5'd8; bus_wr = 1'b1; conv_done = 1'b1;
        @(negedge clk); bus_wr = 1'b0; conv_done = 1'b0;
        chk("R8", "set wins over clear", irq, 1);
        wr(8, 0); wr(9, 0);
        done_pulse(12'h222);
        chk("R8", "disabled no irq", irq, 0);

        // R6 analog output staging
        wr(4, 8'h30);
        chk("R6", "dac0 held after staging", dac0_code, 0);
        wr(5, 8'h12);
        chk("R6", "dac0 loaded", dac0_code, 12'h123);
        wr(6, 8'hE0); wr(7, 8'h9D);
        chk("R6", "dac1 loaded", dac1_code, 12'h9DE);
        chk("R6", "dac0 unaffected", dac0_code, 12'h123);
        rd(5, 0, "R9");

        // R5 digital port
        wr(3, 8'hFA);
        chk("R5", "dio_out", dio_out, 4'hA);
        dio_in = 4'h6; rd(3, 8'h06, "R5");

        // R7 bipolar indication
        bipolar_mode = 1'b1; rd(8, stat(1, 1, 0, 3), "R7");

        // R9 chip selects and unused offsets
        @(negedge clk); bus_addr = 5'd13; bus_rd = 1'b1;
        #1 chk("R9", "tmr_cs at 13", {tmr_cs, pio_cs}, 2'b10);
        chk("R9", "rdata at 13", bus_rdata, 0);
        @(negedge clk); bus_addr = 5'd19;
        #1 chk("R9", "pio_cs at 19", {tmr_cs, pio_cs}, 2'b01);
        @(negedge clk); bus_addr = 5'd11;
        #1 chk("R9", "no cs at 11", {tmr_cs, pio_cs}, 2'b00);
        @(negedge clk); bus_addr = 5'd16; bus_rd = 1'b0;
        #1 chk("R9", "no cs without strobe", {tmr_cs, pio_cs}, 2'b00);

        repeat (3) @(negedge clk);
        if (!done_flag) begin
            done_flag = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    // watchdog
    initial begin
        #(20 * 100000);
        if (!done_flag) begin
            done_flag = 1;
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule